// File: doc/BRIEF.md
# Byte-Wide EEPROM Command Engine

This block puts a byte-addressed non-volatile store behind two 32-bit host registers. The first is a command and status word and the second holds data. To launch one access, the host writes a command word that carries the byte address, a two-bit operation code and a start bit in the top position. That same top bit then reads back as busy for as long as the access is in flight. When busy drops, a read has placed the addressed byte in the data register. A write moves the byte that the host loaded into the data register beforehand into the store.

The backing store is a behavioural byte array. Reads and writes have separate, configurable response latencies. An access is abandoned when the store does not answer within a configurable number of cycles, and the store gives no answer for addresses at or above its populated depth. An abandoned access ends with busy cleared, the store untouched and a sticky timeout flag set in the command word. The host clears that flag by writing a 1 to it.

A command holding nothing but the start bit doubles as a presence check. The host sees that it worked when busy clears and the timeout flag is still 0.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: After reset, both the command word (offset 0) and the data register (offset 4) read as zero.
- R2: A command write with bit 31 = 1 and bits 29:28 = 2'b00 reads the addressed byte. Once busy clears, offset 4 returns that byte in bits 7:0, and bits 31:8 read as zero.
- R3: A byte written to offset 4 (bits 7:0 kept), followed by a command with bit 31 = 1 and bits 29:28 = 2'b11, stores that byte at the address in bits ADDR_W-1:0.
- R4: Busy (bit 31) reads as 1 for exactly RD_LAT sampled cycles after a read launch and for exactly WR_LAT cycles after a write launch.
- R5: An access to an address at or above DEPTH gets no response. After TIMEOUT_CYC cycles, busy clears, bit 17 becomes 1 and the store is left unchanged.
- R6: Bit 17 stays set across later accesses and across command writes that carry a 0 in bit 17. While idle, writing a 1 to bit 17 clears it.
- R7: While busy is 1, host writes to the command word and to the data register have no effect.
- R8: The command word reads back busy in bit 31, the latched operation in bits 29:28, the timeout flag in bit 17 and the latched address in bits 12:0, with every other bit 0.
- R9: The command 0x8000_0000 finishes in RD_LAT cycles and leaves bit 17 at 0.
- R10: Writes to offsets other than 0 and 4 change nothing, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench builds the engine with a 64-byte store, RD_LAT 3, WR_LAT 7 and TIMEOUT_CYC 12. These values keep every latency short enough to count cycle by cycle. Because the latencies differ, a swapped read/write latency shows up. The small depth puts out-of-range addresses a short step above real ones, so an access that wrongly wraps onto a low byte reveals itself when that byte is read back after a timeout.

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine #(
  parameter int ADDR_W      = 13,
  parameter int DEPTH       = 2048,
  parameter int RD_LAT      = 4,
  parameter int WR_LAT      = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam int IW = $clog2(DEPTH);

  logic              busy_q, tmo_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [CW-1:0]     cnt_q;
  logic [7:0]        mem [DEPTH];

  wire sel_cmd  = bus_wr && (bus_addr == 3'd0);
  wire sel_dat  = bus_wr && (bus_addr == 3'd4);
  wire is_wr    = (op_q == 2'b11);
  wire in_range = 32'(addr_q) < DEPTH;
  wire lat_hit  = int'(cnt_q) == (is_wr ? WR_LAT : RD_LAT) - 1;
  wire done     = busy_q && in_range && lat_hit;
  wire expire   = busy_q && !done && (int'(cnt_q) == TIMEOUT_CYC - 1);
  wire [IW-1:0] idx = addr_q[IW-1:0];

  wire unused_bits = ^{bus_wdata[30], bus_wdata[27:18], bus_wdata[16:ADDR_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmo_q  <= 1'b0;
      op_q   <= 2'b00;
      addr_q <= '0;
      data_q <= 8'h00;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        if (!is_wr) data_q <= mem[idx];
      end else if (expire) begin
        busy_q <= 1'b0;
        tmo_q  <= 1'b1;
      end
    end else begin
      if (sel_cmd) begin
        op_q   <= bus_wdata[29:28];
        addr_q <= bus_wdata[ADDR_W-1:0];
        if (bus_wdata[17]) tmo_q <= 1'b0;
        if (bus_wdata[31]) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end
      if (sel_dat) data_q <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (done && is_wr) mem[idx] <= data_q;
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_addr == 3'd0) begin
      bus_rdata[31]         = busy_q;
      bus_rdata[29:28]      = op_q;
      bus_rdata[17]         = tmo_q;
      bus_rdata[ADDR_W-1:0] = addr_q;
    end else if (bus_addr == 3'd4) begin
      bus_rdata[7:0] = data_q;
    end
  end
endmodule

// File: rtl/eeprom_cmd_engine_chk.sv
module eeprom_cmd_engine_chk #(
  parameter int ADDR_W      = 13,
  parameter int TIMEOUT_CYC = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              busy_q,
  input logic              tmo_q,
  input logic [1:0]        op_q,
  input logic [ADDR_W-1:0] addr_q
);
  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= 32'd0;
    else if (busy_q) run <= run + 32'd1;
    else             run <= 32'd0;
  end

  wire cmd_wr = bus_wr && (bus_addr == 3'd0);

  // R2 R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && cmd_wr && bus_wdata[31] |=> busy_q);

  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> run < TIMEOUT_CYC);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cmd_wr |=> $stable(op_q) && $stable(addr_q));

  // R5
  tmo_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $fell(busy_q));

  // R6
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && cmd_wr && bus_wdata[17] && !bus_wdata[31] |=> !tmo_q);
endmodule

bind eeprom_cmd_engine eeprom_cmd_engine_chk #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .busy_q(busy_q), .tmo_q(tmo_q), .op_q(op_q), .addr_q(addr_q)
);

// File: tb/sim_eeprom_cmd_engine.sv
`timescale 1ns/1ps
module sim_eeprom_cmd_engine;
  localparam int AW = 13, DP = 64, RL = 3, WL = 7, TO = 12;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  eeprom_cmd_engine #(.ADDR_W(AW), .DEPTH(DP), .RD_LAT(RL), .WR_LAT(WL), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    for (int i = 0; i < 1000; i++) begin
      rd(3'd0, v);
      if (!v[31]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic put_byte(input int a, input logic [7:0] b);
    int c;
    wr(3'd4, {24'h0, b});
    wr(3'd0, 32'hB000_0000 | a);
    wait_idle(c);
  endtask

  task automatic get_byte(input int a, output logic [31:0] v);
    int c;
    wr(3'd0, 32'h8000_0000 | a);
    wait_idle(c);
    rd(3'd4, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R1 cmd", v, 32'h0);
    rd(3'd4, v); check("R1 data", v, 32'h0);
  endtask

  task automatic t_write_read;
    logic [31:0] v; int c;
    wr(3'd4, 32'h0000_00A5);
    wr(3'd0, 32'hB000_000A);
    rd(3'd0, v); check("R8 busy readback", v, 32'hB000_000A);
    wait_idle(c); check("R4 write latency", 32'(c), 32'(WL));
    rd(3'd0, v); check("R8 idle readback", v, 32'h3000_000A);
    wr(3'd0, 32'h8000_000A);
    wait_idle(c); check("R4 read latency", 32'(c), 32'(RL));
    rd(3'd4, v); check("R2 read byte", v, 32'h0000_00A5);
    wr(3'd4, 32'hFFFF_FF3C);
    wr(3'd0, 32'hB000_003F);
    wait_idle(c);
    get_byte(63, v); check("R3 top address byte", v, 32'h0000_003C);
    get_byte(10, v); check("R2 earlier byte kept", v, 32'h0000_00A5);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v; int c;
    wr(3'd4, 32'h0000_0011);
    wr(3'd0, 32'hB000_0014);
    wr(3'd4, 32'h0000_0099);
    wr(3'd0, 32'h8000_0015);
    wait_idle(c);
    rd(3'd0, v); check("R7 cmd write ignored", v, 32'h3000_0014);
    get_byte(20, v); check("R7 data write ignored", v, 32'h0000_0011);
  endtask

  task automatic t_timeout;
    logic [31:0] v; int c;
    put_byte(5, 8'h5A);
    wr(3'd4, 32'h0000_00EE);
    wr(3'd0, 32'hB000_0000 | (DP + 5));
    wait_idle(c); check("R5 timeout cycles", 32'(c), 32'(TO));
    rd(3'd0, v); check("R5 R8 timeout flag", v, 32'h3002_0045);
    get_byte(5, v); check("R5 store unchanged", v, 32'h0000_005A);
    rd(3'd0, v); check("R6 flag sticky over read", v[17], 1'b1);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, v); check("R6 zero write keeps flag", v, 32'h0002_0000);
    wr(3'd0, 32'h0002_0000);
    rd(3'd0, v); check("R6 write one clears", v, 32'h0);
  endtask

  task automatic t_probe;
    logic [31:0] v; int c;
    wr(3'd0, 32'h8000_0000);
    wait_idle(c); check("R9 probe cycles", 32'(c), 32'(RL));
    rd(3'd0, v); check("R9 probe no timeout", v, 32'h0);
  endtask

  task automatic t_unused;
    logic [31:0] v;
    wr(3'd4, 32'h0000_0042);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R10 offset 2 reads zero", v, 32'h0);
    rd(3'd6, v); check("R10 offset 6 reads zero", v, 32'h0);
    rd(3'd0, v); check("R10 cmd untouched", v, 32'h0);
    rd(3'd4, v); check("R10 data untouched", v, 32'h0000_0042);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_write_read;
    t_busy_ignore;
    t_timeout;
    t_probe;
    t_unused;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule